// File: doc/BRIEF.md
# Carry-Chained Integer ALU

This block is the integer execution unit of a small microcontroller core. Each cycle it takes an opcode, a first source value, a second operand and the current carry flag. It returns a result and the value the carry flag should take next. The second operand is either a register value or an 8-bit immediate that is zero-extended to the data width. The carry flag itself lives outside the block. The core feeds `carry_i` from its flag register and writes `carry_o` back to it.

The unit covers these operations:
- addition and subtraction, each with and without carry-in;
- reverse subtraction, with and without carry-in;
- logical shifts left and right;
- AND, OR, XOR and NOT;
- unsigned minimum and maximum;
- clearing or setting one bit.

For arithmetic, the next carry is the bit just above the data width of the full-precision result, so a subtraction reports a borrow as carry 1. Every other operation passes the incoming carry through unchanged. Results and next-carry are registered, so they appear one clock after the inputs.

The data width `W` is a parameter from 8 to 32 bits. The default is 32.

Top module: `carry_chain_alu`

## Requirements
- R1: When `imm_sel_i` is 1 the second operand (op2) is `imm8_i` zero-extended to W bits, and `src2_i` has no effect. When `imm_sel_i` is 0, op2 is `src2_i` and `imm8_i` has no effect.
- R2: Opcode 0 (add) yields src1+op2, and opcode 1 (add with carry) yields src1+op2+carry_i. In both, result_o is the low W bits and carry_o is bit W of the full sum. Add ignores carry_i.
- R3: Opcode 2 (subtract) yields src1−op2, and opcode 3 (subtract with carry) yields src1−op2−carry_i. result_o is the low W bits and carry_o is 1 exactly when the true difference is negative (borrow). Subtract ignores carry_i.
- R4: Opcode 4 (reverse subtract) yields op2−src1, and opcode 5 yields op2−src1−carry_i. Result and borrow follow the rule of R3.
- R5: Opcode 6 shifts src1 left and opcode 7 shifts it right, both logically, filling with zeros. The shift amount is op2[4:0], and a shift of W or more gives 0.
- R6: Opcodes 8, 9 and 10 yield the bitwise AND, OR and XOR of src1 and op2.
- R7: Opcode 11 yields the bitwise inverse of src1, and op2 has no effect on it.
- R8: Opcodes 12 and 13 yield the unsigned minimum and the unsigned maximum of src1 and op2.
- R9: Opcode 14 clears and opcode 15 sets the bit of src1 at index op2[4:0]. All other bits are kept, and an index of W or more leaves src1 unchanged.
- R10: For opcodes 6 to 15, carry_o equals carry_i.
- R11: Outputs are registered with one cycle of latency. A synchronous active-high `rst` forces result_o and carry_o to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Operation code (see requirements) |
| imm_sel_i | input | 1 | 1 selects the immediate as op2 |
| src1_i | input | W | First source value |
| src2_i | input | W | Register second operand |
| imm8_i | input | 8 | Immediate second operand |
| carry_i | input | 1 | Current carry flag |
| result_o | output | W | Registered result |
| carry_o | output | 1 | Registered next carry flag |

## Verification
The assertions assume that every input is a known value at each rising clock edge outside reset, and that the opcode is always one of the sixteen defined codes. Under those assumptions the one-cycle relations they check are well defined. The bench drives all inputs on the falling edge, so they are stable and defined at each rising edge. It never leaves an input floating after reset. It uses only the 4-bit opcode space, which every code fills.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

  typedef enum logic [3:0] {
    OPC_ADD = 4'd0,
    OPC_ADC = 4'd1,
    OPC_SUB = 4'd2,
    OPC_SUC = 4'd3,
    OPC_RSB = 4'd4,
    OPC_RSC = 4'd5,
    OPC_LSL = 4'd6,
    OPC_LSR = 4'd7,
    OPC_AND = 4'd8,
    OPC_OR  = 4'd9,
    OPC_XOR = 4'd10,
    OPC_NOT = 4'd11,
    OPC_MIN = 4'd12,
    OPC_MAX = 4'd13,
    OPC_CLR = 4'd14,
    OPC_SET = 4'd15
  } alu_opc_e;

  localparam int unsigned SHAMT_BITS = 5;

  // Control bundle that steers the adder/subtractor.
  typedef struct packed {
    logic is_sub;   // subtract instead of add
    logic rev;      // swap operands (op2 - src1)
    logic use_cy;   // fold carry flag in
  } arith_ctl_t;

  function automatic logic opc_is_arith(input logic [3:0] opc);
    return (opc <= OPC_RSC);
  endfunction

  function automatic arith_ctl_t decode_arith(input logic [3:0] opc);
    arith_ctl_t c;
    c.is_sub = (opc != OPC_ADD) && (opc != OPC_ADC);
    c.rev    = (opc == OPC_RSB) || (opc == OPC_RSC);
    c.use_cy = (opc == OPC_ADC) || (opc == OPC_SUC) || (opc == OPC_RSC);
    return c;
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned W      = 32,
  parameter int unsigned IMM_W  = 8
) (
  input  logic             imm_sel_i,
  input  logic [W-1:0]     src2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     op2_o
);

  localparam int unsigned PAD_W = W - IMM_W;

  logic [W-1:0] imm_ext;

  generate
    if (PAD_W == 0) begin : g_no_pad
      assign imm_ext = imm_i;
    end else begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm_i};
    end
  endgenerate

  assign op2_o = imm_sel_i ? imm_ext : src2_i;

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import carry_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  arith_ctl_t   ctl_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] op2_i,
  input  logic         carry_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);

  localparam int unsigned XW = W + 1;

  logic [W-1:0]  lhs;
  logic [W-1:0]  rhs;
  logic [XW-1:0] lhs_x;
  logic [XW-1:0] rhs_x;
  logic [XW-1:0] cin_x;
  logic [XW-1:0] full;

  always_comb begin
    lhs   = ctl_i.rev ? op2_i  : src1_i;
    rhs   = ctl_i.rev ? src1_i : op2_i;
    lhs_x = {1'b0, lhs};
    rhs_x = {1'b0, rhs};
    cin_x = {{W{1'b0}}, (ctl_i.use_cy & carry_i)};
    if (ctl_i.is_sub) begin
      full = lhs_x - rhs_x - cin_x;
    end else begin
      full = lhs_x + rhs_x + cin_x;
    end
  end

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import carry_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   opc_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] op2_i,
  output logic [W-1:0] res_o
);

  logic [SHAMT_BITS-1:0] amt;
  logic [W-1:0]          onehot;
  logic [W-1:0]          shl;
  logic [W-1:0]          shr;
  logic                  lt;

  assign amt = op2_i[SHAMT_BITS-1:0];

  // Bit-index decoder: bits at index >= W never match, so such an index
  // changes nothing.
  generate
    for (genvar i = 0; i < W; i++) begin : g_dec
      assign onehot[i] = (amt == SHAMT_BITS'(i));
    end
  endgenerate

  assign shl = src1_i << amt;
  assign shr = src1_i >> amt;
  assign lt  = (src1_i < op2_i);

  always_comb begin
    unique case (opc_i)
      OPC_LSL: res_o = shl;
      OPC_LSR: res_o = shr;
      OPC_AND: res_o = src1_i & op2_i;
      OPC_OR:  res_o = src1_i | op2_i;
      OPC_XOR: res_o = src1_i ^ op2_i;
      OPC_NOT: res_o = ~src1_i;
      OPC_MIN: res_o = lt ? src1_i : op2_i;
      OPC_MAX: res_o = lt ? op2_i  : src1_i;
      OPC_CLR: res_o = src1_i & ~onehot;
      OPC_SET: res_o = src1_i | onehot;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/carry_chain_alu.sv
module carry_chain_alu
  import carry_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   opcode_i,
  input  logic         imm_sel_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [7:0]   imm8_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o
);

  localparam int unsigned IMM_W = 8;

  logic [W-1:0] op2;
  logic [W-1:0] arith_res;
  logic         arith_cy;
  logic [W-1:0] logic_res;
  logic         is_arith;
  arith_ctl_t   actl;
  logic [W-1:0] res_d;
  logic         cy_d;
  logic [W-1:0] res_q;
  logic         cy_q;

  alu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .imm_sel_i (imm_sel_i),
    .src2_i    (src2_i),
    .imm_i     (imm8_i),
    .op2_o     (op2)
  );

  assign actl     = decode_arith(opcode_i);
  assign is_arith = opc_is_arith(opcode_i);

  alu_arith_unit #(.W(W)) u_arith (
    .ctl_i   (actl),
    .src1_i  (src1_i),
    .op2_i   (op2),
    .carry_i (carry_i),
    .sum_o   (arith_res),
    .carry_o (arith_cy)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .opc_i  (opcode_i),
    .src1_i (src1_i),
    .op2_i  (op2),
    .res_o  (logic_res)
  );

  assign res_d = is_arith ? arith_res : logic_res;
  assign cy_d  = is_arith ? arith_cy  : carry_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      cy_q  <= cy_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = cy_q;

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_o == '0) && !carry_o);

  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i > OPC_RSC) |=> (carry_o == $past(carry_i)));

  // R7
  not_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i == OPC_NOT) |=> (result_o == ~$past(src1_i)));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i == OPC_ADD) |=>
      ({carry_o, result_o} == ($past({1'b0, src1_i}) + $past({1'b0, op2}))));

  // R8
  min_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i == OPC_MIN) |=>
      (result_o <= $past(src1_i)) && (result_o <= $past(op2)));

  // R8
  max_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i == OPC_MAX) |=>
      (result_o >= $past(src1_i)) && (result_o >= $past(op2)));

  // R9
  bit_edit_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode_i >= OPC_CLR) |=> ($countones(result_o ^ $past(src1_i)) <= 1));

endmodule

// File: tb/carry_chain_alu_tb.sv
module carry_chain_alu_tb_top;

  localparam int unsigned W = 32;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   opcode_i = '0;
  logic         imm_sel_i = 1'b0;
  logic [W-1:0] src1_i = '0;
  logic [W-1:0] src2_i = '0;
  logic [7:0]   imm8_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] result_o;
  logic         carry_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  carry_chain_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .imm_sel_i(imm_sel_i),
    .src1_i(src1_i), .src2_i(src2_i), .imm8_i(imm8_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  // Reference model: 64-bit intermediate, result and carry taken from it.
  function automatic logic [W:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic c);
    logic [63:0] x, y, r;
    logic        cy;
    x = 64'(a); y = 64'(b); cy = c;
    case (op)
      4'd0:  begin r = x + y;               cy = r[W]; end
      4'd1:  begin r = x + y + 64'(c);      cy = r[W]; end
      4'd2:  begin r = x - y;               cy = r[W]; end
      4'd3:  begin r = x - y - 64'(c);      cy = r[W]; end
      4'd4:  begin r = y - x;               cy = r[W]; end
      4'd5:  begin r = y - x - 64'(c);      cy = r[W]; end
      4'd6:  r = x << y[4:0];
      4'd7:  r = x >> y[4:0];
      4'd8:  r = x & y;
      4'd9:  r = x | y;
      4'd10: r = x ^ y;
      4'd11: r = ~x;
      4'd12: r = (x < y) ? x : y;
      4'd13: r = (x > y) ? x : y;
      4'd14: r = x & ~(64'd1 << y[4:0]);
      default: r = x | (64'd1 << y[4:0]);
    endcase
    return {cy, r[W-1:0]};
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got carry=%0b res=%h expected carry=%0b res=%h",
               req, got[W], got[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  // Drive on the falling edge, sample one rising edge later.
  task automatic run_op(input string req, input logic [3:0] op, input logic isel,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [7:0] imm, input logic c);
    logic [W-1:0] op2;
    @(negedge clk);
    opcode_i = op; imm_sel_i = isel; src1_i = a; src2_i = b; imm8_i = imm; carry_i = c;
    op2 = isel ? W'(imm) : b;
    @(posedge clk);
    #1;
    check(req, {carry_o, result_o}, model(op, a, op2, c));
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; opcode_i = 4'd1; src1_i = ONES; src2_i = ONES; carry_i = 1'b1;
    @(posedge clk); #1;
    check("R11 reset", {carry_o, result_o}, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_latency;
    run_op("R11 latency", 4'd0, 1'b0, 32'd5, 32'd7, 8'd0, 1'b0);
    @(negedge clk);
    src1_i = 32'd100;
    #1;
    check("R11 held until edge", {carry_o, result_o}, {1'b0, 32'd12});
  endtask

  task automatic t_operand;
    run_op("R1 imm ignores src2", 4'd0, 1'b1, 32'h10, 32'hDEAD_BEEF, 8'hFF, 1'b0);
    run_op("R1 src2 ignores imm", 4'd0, 1'b0, 32'h10, 32'h20, 8'hAA, 1'b0);
    run_op("R1 imm zero-ext", 4'd8, 1'b1, ONES, ONES, 8'h81, 1'b0);
  endtask

  task automatic t_add;
    run_op("R2 add overflow", 4'd0, 1'b0, ONES, 32'd1, 8'd0, 1'b1);
    run_op("R2 adc carry in", 4'd1, 1'b0, ONES, 32'd0, 8'd0, 1'b1);
    run_op("R2 adc no carry", 4'd1, 1'b0, 32'd3, 32'd4, 8'd0, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R3 sub borrow", 4'd2, 1'b0, 32'd0, 32'd1, 8'd0, 1'b1);
    run_op("R3 sub equal", 4'd2, 1'b0, SIGN, SIGN, 8'd0, 1'b1);
    run_op("R3 suc borrow", 4'd3, 1'b0, 32'd5, 32'd5, 8'd0, 1'b1);
    run_op("R4 rsb", 4'd4, 1'b1, 32'd3, 32'd0, 8'd10, 1'b0);
    run_op("R4 rsb borrow", 4'd4, 1'b0, 32'd9, 32'd2, 8'd0, 1'b0);
    run_op("R4 rsc", 4'd5, 1'b0, 32'd2, 32'd2, 8'd0, 1'b1);
  endtask

  task automatic t_shift;
    run_op("R5 lsl mask", 4'd6, 1'b1, 32'd1, 32'd0, 8'd35, 1'b1);
    run_op("R5 lsr logical", 4'd7, 1'b0, SIGN, 32'd31, 8'd0, 1'b0);
    run_op("R5 lsl zero fill", 4'd6, 1'b0, ONES, 32'd4, 8'd0, 1'b0);
  endtask

  task automatic t_logic;
    run_op("R6 and", 4'd8, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF, 8'd0, 1'b0);
    run_op("R6 or", 4'd9, 1'b0, 32'hF000_0000, 32'h0000_000F, 8'd0, 1'b1);
    run_op("R6 xor", 4'd10, 1'b0, ONES, 32'h1234_5678, 8'd0, 1'b0);
    run_op("R7 not ignores op2 a", 4'd11, 1'b0, 32'h0F0F_0000, 32'd0, 8'd0, 1'b0);
    run_op("R7 not ignores op2 b", 4'd11, 1'b1, 32'h0F0F_0000, ONES, 8'hFF, 1'b1);
  endtask

  task automatic t_minmax;
    run_op("R8 min unsigned", 4'd12, 1'b0, SIGN, 32'd1, 8'd0, 1'b0);
    run_op("R8 max unsigned", 4'd13, 1'b0, SIGN, 32'h7FFF_FFFF, 8'd0, 1'b0);
    run_op("R8 min imm", 4'd12, 1'b1, 32'd300, 32'd0, 8'd200, 1'b1);
  endtask

  task automatic t_bits;
    run_op("R9 clr", 4'd14, 1'b0, ONES, 32'd31, 8'd0, 1'b0);
    run_op("R9 set masked", 4'd15, 1'b1, 32'd0, 32'd0, 8'd33, 1'b1);
    run_op("R9 set already", 4'd15, 1'b0, 32'd4, 32'd2, 8'd0, 1'b0);
  endtask

  task automatic t_carry_hold;
    for (int op = 6; op < 16; op++) begin
      run_op("R10 carry hold 1", 4'(op), 1'b0, ONES, ONES, 8'd0, 1'b1);
      run_op("R10 carry hold 0", 4'(op), 1'b0, ONES, 32'd1, 8'd0, 1'b0);
    end
  endtask

  task automatic t_sweep;
    logic [W-1:0] corners [4];
    corners[0] = '0; corners[1] = ONES; corners[2] = SIGN; corners[3] = SIGN - 1;
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          run_op("R2-sweep corners", 4'(op), 1'b0, corners[i], corners[j], 8'd0, 1'(i ^ j));
        end
      end
      for (int k = 0; k < 12; k++) begin
        run_op("R3 random", 4'(op), 1'($urandom), $urandom, $urandom, 8'($urandom), 1'($urandom));
      end
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_operand();
    t_add();
    t_sub();
    t_shift();
    t_logic();
    t_minmax();
    t_bits();
    t_carry_hold();
    t_sweep();
    t_reset();
    finish_run();
  end

endmodule